// File: doc/BRIEF.md
# Composite Sync Separator with Polarity Detection

This block takes a composite sync line and recovers the vertical sync from it. A duration filter runs on a 5 MHz reference tick, which arrives as a single-cycle enable in the system clock domain. The filter changes its output level only after the input has stayed at the opposite level for a programmable number of ticks. Short horizontal pulses and serrations are therefore dropped, and only the long vertical interval gets through. For correct operation the threshold must exceed the widest horizontal pulse, measured in ticks.

Two detectors measure how many ticks a line spends high and how many it spends low over each full period. The level that occupies the smaller share is taken as the active level. One detector watches the synchronized input and the other watches the filtered vertical signal. Both results appear as status bits. The horizontal polarity can be forced by software through an override bit. Both sync outputs are normalized so that they are active high.

Top module: `csync_separator`

## Requirements
- R1: After reset the outputs read as follows, with the override bit clear: `vsync_out` 0, `hsync_out` 0, `hpol_status` 1 and `vpol_status` 1.
- R2: `csync_in` passes through a two-flop synchronizer. A change on the input reaches `hsync_out` at the second rising clock edge after it is applied.
- R3: The filter output changes level on the tick where the synchronized input has differed from it on N consecutive ticks, counting that tick. N is `sep_thresh`.
- R4: If the input returns to the filter's level before N is reached, the run count clears and the filter output keeps its level.
- R5: A `sep_thresh` of 0 behaves exactly like a threshold of 1.
- R6: Cycles without `tick_5m` change neither the filter state nor the polarity state.
- R7: At each rising edge of the synchronized input after the first, the horizontal detector compares the high-tick and low-tick counts of the period that just ended. It records 1 (positive) if the high count is smaller, 0 (negative) if it is larger, and keeps its value if the counts are equal.
- R8: The vertical detector applies the rule of R7 to the filter output. It reports 1 for active high and 0 for active low.
- R9: The selected horizontal polarity is `hpol_user` when `hpol_override` is 1, and the detected value otherwise. `hsync_out` equals the synchronized input XOR the inverse of the selected polarity.
- R10: `vsync_out` equals the filter output XOR the inverse of the detected vertical polarity, so the vertical interval reads 1 for either input polarity.
- R11: `hpol_status` always shows the detected polarity, whatever the override bit and `hpol_user` are set to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_5m | input | 1 | Single-cycle 5 MHz reference enable |
| csync_in | input | 1 | Composite sync input, asynchronous |
| sep_thresh | input | 8 | Filter threshold in ticks |
| hpol_override | input | 1 | 1 selects the software horizontal polarity |
| hpol_user | input | 1 | Software horizontal polarity, 1 = positive |
| vsync_out | output | 1 | Recovered vertical sync, active high |
| hsync_out | output | 1 | Normalized horizontal sync, active high |
| hpol_status | output | 1 | Detected horizontal polarity, 1 = positive |
| vpol_status | output | 1 | Detected vertical polarity, 1 = active high |

## Verification
A single tick can end a filter run and close a polarity period at the same edge. In that case the vertical detector must see the filter level from before the toggle, not the new one. The bench provokes this with lines whose vertical interval begins exactly one threshold after a rising edge. It also uses random ticks and random thresholds, including 0, so that toggles and period closures coincide. It judges every cycle against a reference model that updates all state from the values held before the edge.

// File: rtl/csync_pkg.sv
package csync_pkg;

    localparam int TH_W   = 8;
    localparam int PCNT_W = 16;

    typedef enum logic {
        POL_NEG = 1'b0,
        POL_POS = 1'b1
    } pol_e;

    typedef struct packed {
        logic [PCNT_W-1:0] hi;
        logic [PCNT_W-1:0] lo;
    } dwell_t;

    // zero threshold behaves like one
    function automatic logic [TH_W-1:0] eff_thresh(input logic [TH_W-1:0] t);
        return (t == '0) ? TH_W'(1) : t;
    endfunction

    function automatic logic [PCNT_W-1:0] sat_inc(input logic [PCNT_W-1:0] v);
        return (&v) ? v : v + PCNT_W'(1);
    endfunction

    // the level that occupies less of the period is the active one
    function automatic pol_e judge(input dwell_t d, input pol_e old);
        if (d.hi < d.lo)      return POL_POS;
        else if (d.hi > d.lo) return POL_NEG;
        else                  return old;
    endfunction

endpackage

// File: rtl/csync_sync.sv
module csync_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         chain_q[g] <= 1'b0;
                else if (g == 0) chain_q[g] <= din;
                else             chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/csync_dur_filter.sv
module csync_dur_filter
    import csync_pkg::*;
#(
    parameter int W = TH_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         din,
    input  logic [W-1:0] thresh,
    output logic         dout
);
    localparam int CW = W + 1;

    logic         out_q;
    logic [W-1:0] run_q;
    logic [W-1:0] lim;
    logic [CW-1:0] run_next;

    assign lim      = eff_thresh(thresh);
    assign run_next = {1'b0, run_q} + CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
            run_q <= '0;
        end else if (tick) begin
            if (din != out_q) begin
                if (run_next >= {1'b0, lim}) begin
                    out_q <= din;
                    run_q <= '0;
                end else begin
                    run_q <= run_next[W-1:0];
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assign dout = out_q;

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(out_q) && $stable(run_q)));

    // R3
    toggle_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_q) |-> ($past(tick) && ($past(din) != $past(out_q))));

    // R4
    run_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && (din == out_q)) |=> (run_q == '0 && $stable(out_q)));
endmodule

// File: rtl/csync_pol_detect.sv
module csync_pol_detect
    import csync_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic din,
    output logic pol
);
    logic   prev_q;
    logic   armed_q;
    dwell_t dw_q;
    pol_e   pol_q;
    logic   rise;

    assign rise = din & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
            dw_q    <= '0;
            pol_q   <= POL_POS;
        end else if (tick) begin
            prev_q <= din;
            if (rise) begin
                if (armed_q) pol_q <= judge(dw_q, pol_q);
                armed_q <= 1'b1;
                dw_q.hi <= PCNT_W'(1);
                dw_q.lo <= '0;
            end else if (din) begin
                dw_q.hi <= sat_inc(dw_q.hi);
            end else begin
                dw_q.lo <= sat_inc(dw_q.lo);
            end
        end
    end

    assign pol = pol_q;

    // R6
    pol_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pol_q));

    // R7
    pol_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pol_q) |-> ($past(tick) && $past(din) && !$past(prev_q) && $past(armed_q)));
endmodule

// File: rtl/csync_separator.sv
module csync_separator
    import csync_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_5m,
    input  logic             csync_in,
    input  logic [TH_W-1:0]  sep_thresh,
    input  logic             hpol_override,
    input  logic             hpol_user,
    output logic             vsync_out,
    output logic             hsync_out,
    output logic             hpol_status,
    output logic             vpol_status
);
    localparam int NDET = 2;
    localparam int IDX_H = 0;
    localparam int IDX_V = 1;

    logic            sync_lvl;
    logic            filt_lvl;
    logic [NDET-1:0] det_in;
    logic [NDET-1:0] det_pol;
    logic            hpol_sel;

    csync_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (csync_in),
        .dout(sync_lvl)
    );

    csync_dur_filter #(.W(TH_W)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_5m),
        .din   (sync_lvl),
        .thresh(sep_thresh),
        .dout  (filt_lvl)
    );

    assign det_in[IDX_H] = sync_lvl;
    assign det_in[IDX_V] = filt_lvl;

    genvar g;
    generate
        for (g = 0; g < NDET; g++) begin : g_det
            csync_pol_detect u_det (
                .clk (clk),
                .rst (rst),
                .tick(tick_5m),
                .din (det_in[g]),
                .pol (det_pol[g])
            );
        end
    endgenerate

    assign hpol_sel    = hpol_override ? hpol_user : det_pol[IDX_H];
    assign hsync_out   = sync_lvl ^ ~hpol_sel;
    assign vsync_out   = filt_lvl ^ ~det_pol[IDX_V];
    assign hpol_status = det_pol[IDX_H];
    assign vpol_status = det_pol[IDX_V];

    // R11
    status_free_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(hpol_status) || $past(tick_5m)));
endmodule

// File: tb/csync_separator_tb.sv
module csync_separator_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_5m = 1'b0;
    logic       csync_in = 1'b0;
    logic [7:0] sep_thresh = 8'd8;
    logic       hpol_override = 1'b0;
    logic       hpol_user = 1'b0;
    logic       vsync_out, hsync_out, hpol_status, vpol_status;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    csync_separator dut_i (
        .clk(clk), .rst(rst), .tick_5m(tick_5m), .csync_in(csync_in),
        .sep_thresh(sep_thresh), .hpol_override(hpol_override),
        .hpol_user(hpol_user), .vsync_out(vsync_out), .hsync_out(hsync_out),
        .hpol_status(hpol_status), .vpol_status(vpol_status)
    );

    // reference model state
    logic m_s1, m_s2, m_out, o_s2, o_out;
    int   m_cnt;
    logic p_prev [2];
    logic p_arm  [2];
    int   p_hi   [2];
    int   p_lo   [2];
    logic p_pol  [2];

    function automatic int eff(input logic [7:0] t);
        return (t == 0) ? 1 : int'(t);
    endfunction

    function automatic logic decide(input int hi, input int lo, input logic old);
        if (hi < lo) return 1'b1;
        if (hi > lo) return 1'b0;
        return old;
    endfunction

    function automatic int sat(input int v);
        return (v >= 65535) ? 65535 : v + 1;
    endfunction

    task automatic pol_step(input int i, input logic d);
        if (d && !p_prev[i]) begin
            if (p_arm[i]) p_pol[i] = decide(p_hi[i], p_lo[i], p_pol[i]);
            p_arm[i] = 1'b1; p_hi[i] = 1; p_lo[i] = 0;
        end else if (d) p_hi[i] = sat(p_hi[i]);
        else            p_lo[i] = sat(p_lo[i]);
        p_prev[i] = d;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_out = 0; m_cnt = 0;
            for (int i = 0; i < 2; i++) begin
                p_prev[i] = 0; p_arm[i] = 0; p_hi[i] = 0; p_lo[i] = 0; p_pol[i] = 1;
            end
        end else begin
            o_s2 = m_s2; o_out = m_out;
            m_s2 = m_s1; m_s1 = csync_in;
            if (tick_5m) begin
                if (o_s2 != o_out) begin
                    if (m_cnt + 1 >= eff(sep_thresh)) begin m_out = o_s2; m_cnt = 0; end
                    else m_cnt = m_cnt + 1;
                end else m_cnt = 0;
                pol_step(0, o_s2);
                pol_step(1, o_out);
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic hsel;
        if (rst) return;
        hsel = hpol_override ? hpol_user : p_pol[0];
        chk("R3 R4 R10 vsync_out", vsync_out, m_out ^ ~p_pol[1]);
        chk("R2 R9 hsync_out", hsync_out, m_s2 ^ ~hsel);
        chk("R7 R11 hpol_status", hpol_status, p_pol[0]);
        chk("R8 vpol_status", vpol_status, p_pol[1]);
    endtask

    task automatic cyc(input logic d, input logic tk);
        @(negedge clk);
        compare();
        csync_in = d;
        tick_5m  = tk;
    endtask

    task automatic tick_slot(input logic d);
        for (int k = 0; k < 4; k++) cyc(d, k == 0);
    endtask

    // 15 lines of 20 ticks, lines 5..7 carry the vertical interval
    task automatic frame(input logic pol, input bit check_v);
        for (int l = 0; l < 15; l++) begin
            for (int t = 0; t < 20; t++) begin
                bit vert;
                logic lvl;
                vert = (l >= 5 && l < 8);
                lvl  = vert ? ((t < 17) ? pol : ~pol) : ((t < 3) ? pol : ~pol);
                if (check_v && l == 7 && t == 0) chk("R10 vsync in vertical", vsync_out, 1'b1);
                if (check_v && l == 12 && t == 10) chk("R3 hsync pulses blocked", vsync_out, 1'b0);
                tick_slot(lvl);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7031));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 vsync_out", vsync_out, 1'b0);
        chk("R1 hsync_out", hsync_out, 1'b0);
        chk("R1 hpol_status", hpol_status, 1'b1);
        chk("R1 vpol_status", vpol_status, 1'b1);

        // R2 synchronizer latency, no ticks: R6 filter idle
        cyc(1'b1, 1'b0);
        @(negedge clk); chk("R2 first edge", hsync_out, 1'b0);
        @(negedge clk); chk("R2 second edge", hsync_out, 1'b1);
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0);
        chk("R6 no tick no toggle", vsync_out, 1'b0);

        // positive composite sync
        for (int f = 0; f < 4; f++) frame(1'b1, f >= 2);
        chk("R7 positive detected", hpol_status, 1'b1);
        chk("R8 active high detected", vpol_status, 1'b1);

        // negative composite sync
        for (int f = 0; f < 4; f++) frame(1'b0, f >= 2);
        chk("R7 negative detected", hpol_status, 1'b0);
        chk("R8 active low detected", vpol_status, 1'b0);

        // override
        hpol_override = 1'b1; hpol_user = 1'b1;
        for (int f = 0; f < 2; f++) frame(1'b0, 1'b1);
        chk("R11 status ignores override", hpol_status, 1'b0);
        chk("R9 user positive, idle high", hsync_out, 1'b1);
        hpol_user = 1'b0;
        #0; chk("R9 user negative, idle high", hsync_out, 1'b0);
        hpol_override = 1'b0;

        // R4 a run one short of the threshold
        sep_thresh = 8'd8;
        for (int i = 0; i < 10; i++) tick_slot(1'b1);
        for (int i = 0; i < 7; i++) tick_slot(1'b0);
        for (int i = 0; i < 7; i++) tick_slot(1'b1);
        for (int i = 0; i < 7; i++) tick_slot(1'b0);
        chk("R4 short runs ignored", vsync_out, 1'b0);

        // R5 threshold zero acts as one
        sep_thresh = 8'd0;
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1);
        chk("R5 thr0 follows input", vsync_out, 1'b1);
        cyc(1'b1, 1'b1);
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1);

        // random section: R3 R4 R5 R6 R9 coincidences
        for (int n = 0; n < 400; n++) begin
            int len;
            logic lvl;
            lvl = logic'($urandom_range(0, 1));
            len = $urandom_range(1, 40);
            if ($urandom_range(0, 9) == 0) sep_thresh = 8'($urandom_range(0, 9));
            if ($urandom_range(0, 19) == 0) hpol_override = ~hpol_override;
            if ($urandom_range(0, 9) == 0) hpol_user = ~hpol_user;
            for (int k = 0; k < len; k++) cyc(lvl, $urandom_range(0, 2) == 0);
        end
        @(negedge clk); compare();

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule